// File: doc/BRIEF.md
# Ethernet DMA Descriptor Ring Walker

This block walks the receive and transmit descriptor rings of an Ethernet DMA. Each descriptor takes two 32-bit words in descriptor memory. The first word carries a 16-bit status field in bits 31:16 and a 16-bit byte count in bits 15:0. The second word, at offset 4, holds the buffer pointer. Descriptors lie 8 bytes apart. Software places each ring at a base address aligned to 16 bytes. It marks the final descriptor of a ring with a wrap flag, so no ring length is programmed anywhere.

Each ring has its own engine. An engine reads a descriptor's status word. If it owns the descriptor, it also reads the pointer and offers the descriptor to the MAC side. When the MAC signals completion, the engine writes the status word back, which hands the descriptor to software. It then moves to the next descriptor. When the engine meets a descriptor it does not own, it drops its active flag and stays idle until software writes the activate register again. Both engines share one memory port, and the receive engine has priority on it.

Top module: `dma_ring_walker`

## Requirements
- R1: After reset, and while `enable` is low, there is no memory access, and `rx_active`, `tx_active`, `rx_valid` and `tx_valid` are all low.
- R2: Once activated, an engine's first access is a read of the status word at its ring base address, with base bits 3:0 treated as zero.
- R3: An engine that reads a status word with bit 31 (owned) clear lowers its active flag. It then makes no memory access until it is activated again.
- R4: For an owned receive descriptor, `rx_valid` rises and `rx_buf_ptr` shows the descriptor's second word. Both hold until `rx_done`.
- R5: On `rx_done`, the receive engine makes exactly one write to the status word, and that write closes the descriptor. The owned flag (status bit 15, word bit 31) is cleared. Last (bit 11) takes the value of `rx_last` and error (bit 0) takes the value of `rx_err`. Wrap (bit 13) is kept. The length becomes `rx_len`, plus 4 when `rx_last` is set.
- R6: For an owned transmit descriptor, `tx_valid` presents the descriptor's pointer and length, its last flag (bit 11) and its transmit-CRC flag (bit 10).
- R7: On `tx_done`, the transmit engine rewrites the status word with only the ready flag (bit 15) cleared. All other status bits and the length are unchanged.
- R8: After a descriptor with wrap set, the next status read is at the ring base address. Otherwise the next status read is 8 bytes further on.
- R9: A write to the activate port (`act_we`) restarts the engines selected in `act_target` (bit 0 receive, bit 1 transmit) only when `act_data` bit 24 is set. Any other value has no effect.
- R10: When both engines request the memory port in the same cycle, the receive engine is served first. The transmit engine's access follows, and both rings complete.
- R11: Taking `enable` low returns both current indices to their base addresses, so the next activation starts at the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low resets indices and idles both engines |
| rx_base | input | 32 | Receive ring base address |
| tx_base | input | 32 | Transmit ring base address |
| act_we | input | 1 | Activate register write strobe |
| act_target | input | 2 | Engines addressed by the write: bit 0 receive, bit 1 transmit |
| act_data | input | 32 | Activate register write data; bit 24 starts polling |
| mem_req | output | 1 | Descriptor memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read access |
| rx_active | output | 1 | Receive engine is polling |
| rx_valid | output | 1 | Owned receive descriptor offered to the MAC |
| rx_buf_ptr | output | 32 | Receive buffer pointer |
| rx_done | input | 1 | MAC finished filling the offered buffer |
| rx_len | input | 16 | Bytes received, without the frame check sequence |
| rx_last | input | 1 | Buffer ends a frame |
| rx_err | input | 1 | Frame received with an error |
| tx_active | output | 1 | Transmit engine is polling |
| tx_valid | output | 1 | Owned transmit descriptor offered to the MAC |
| tx_buf_ptr | output | 32 | Transmit buffer pointer |
| tx_len | output | 16 | Transmit byte count |
| tx_last | output | 1 | Descriptor ends a frame |
| tx_crc | output | 1 | MAC is to append the CRC |
| tx_done | input | 1 | MAC finished sending the offered buffer |

## Verification
The two engines can ask for the single descriptor memory port in the same cycle. The bench provokes this by activating both rings with one write to the activate port, so both engines fetch their first status word together. It then judges the order of the logged memory addresses: the receive base must come first and the transmit base directly after. Every descriptor of both rings must still be served and closed correctly. This is repeated for ring sizes one to four, so the two engines also collide on writebacks and pointer reads at varying offsets.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RDST, S_WTST, S_RDPTR, S_WTPTR, S_SERVE, S_WB
  } eng_state_t;

  // status field bit positions (status = descriptor word0[31:16])
  localparam int ST_OWN  = 15;
  localparam int ST_WRAP = 13;
  localparam int ST_LAST = 11;
  localparam int ST_CRC  = 10;
  localparam int ST_ERR  = 0;

  localparam int FCS_BYTES   = 4;
  localparam int DESC_STRIDE = 8;
  localparam int PTR_OFFSET  = 4;
  localparam int ACT_BIT     = 24;
endpackage

// File: rtl/dwr_act_decode.sv
module dwr_act_decode #(
  parameter int DW = 32,
  parameter int NENG = 2
) (
  input  logic            enable,
  input  logic            act_we,
  input  logic [NENG-1:0] act_target,
  input  logic [DW-1:0]   act_data,
  output logic [NENG-1:0] act_hit
);
  import dwr_pkg::*;
  logic start;
  assign start = enable && act_we && act_data[ACT_BIT];

  for (genvar g = 0; g < NENG; g++) begin : g_hit
    assign act_hit[g] = start && act_target[g];
  end
endmodule

// File: rtl/dwr_ring_engine.sv
module dwr_ring_engine #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16,
  parameter bit IS_RX = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [AW-1:0] base,
  input  logic          act,
  input  logic          gnt,
  input  logic [DW-1:0] rdata,
  output logic          req,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          active,
  output logic          valid,
  output logic [AW-1:0] buf_ptr,
  output logic [LW-1:0] desc_len,
  output logic          desc_last,
  output logic          desc_crc,
  input  logic          done,
  input  logic [LW-1:0] done_len,
  input  logic          done_last,
  input  logic          done_err
);
  import dwr_pkg::*;
  localparam int SW = DW - LW;

  eng_state_t    state_q, state_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [SW-1:0] st_q, st_d;
  logic [LW-1:0] len_q, len_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          poke_q, poke_d;
  logic [LW-1:0] lat_len_q, lat_len_d;
  logic          lat_last_q, lat_last_d;
  logic          lat_err_q, lat_err_d;

  logic [AW-1:0] base_al;
  logic [SW-1:0] st_wb;
  logic [LW-1:0] len_wb;

  assign base_al = {base[AW-1:4], 4'b0000};

  // writeback word: receive closes with MAC results, transmit only drops ready
  always_comb begin
    if (IS_RX) begin
      st_wb = st_q;
      st_wb[ST_OWN]  = 1'b0;
      st_wb[ST_LAST] = lat_last_q;
      st_wb[ST_ERR]  = lat_err_q;
      len_wb = lat_last_q ? lat_len_q + LW'(FCS_BYTES) : lat_len_q;
    end else begin
      st_wb = st_q;
      st_wb[ST_OWN] = 1'b0;
      len_wb = len_q;
    end
  end

  always_comb begin
    state_d    = state_q;
    cur_d      = cur_q;
    st_d       = st_q;
    len_d      = len_q;
    ptr_d      = ptr_q;
    lat_len_d  = lat_len_q;
    lat_last_d = lat_last_q;
    lat_err_d  = lat_err_q;
    poke_d     = act ? 1'b1 : ((state_q == S_RDST && gnt) ? 1'b0 : poke_q);
    req   = 1'b0;
    we    = 1'b0;
    addr  = cur_q;
    wdata = {st_wb, len_wb};
    if (!enable) begin
      state_d = S_IDLE;
      cur_d   = base_al;
      poke_d  = 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (act || poke_q) state_d = S_RDST;
        S_RDST: begin
          req = 1'b1;
          if (gnt) state_d = S_WTST;
        end
        S_WTST: begin
          st_d  = rdata[DW-1:LW];
          len_d = rdata[LW-1:0];
          if (rdata[LW + ST_OWN])      state_d = S_RDPTR;
          else if (poke_q || act)      state_d = S_RDST;
          else                         state_d = S_IDLE;
        end
        S_RDPTR: begin
          req  = 1'b1;
          addr = cur_q + AW'(PTR_OFFSET);
          if (gnt) state_d = S_WTPTR;
        end
        S_WTPTR: begin
          ptr_d   = rdata[AW-1:0];
          state_d = S_SERVE;
        end
        S_SERVE: if (done) begin
          lat_len_d  = done_len;
          lat_last_d = done_last;
          lat_err_d  = done_err;
          state_d    = S_WB;
        end
        S_WB: begin
          req = 1'b1;
          we  = 1'b1;
          if (gnt) begin
            cur_d   = st_q[ST_WRAP] ? base_al : cur_q + AW'(DESC_STRIDE);
            state_d = S_RDST;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      cur_q      <= '0;
      st_q       <= '0;
      len_q      <= '0;
      ptr_q      <= '0;
      poke_q     <= 1'b0;
      lat_len_q  <= '0;
      lat_last_q <= 1'b0;
      lat_err_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      cur_q      <= cur_d;
      st_q       <= st_d;
      len_q      <= len_d;
      ptr_q      <= ptr_d;
      poke_q     <= poke_d;
      lat_len_q  <= lat_len_d;
      lat_last_q <= lat_last_d;
      lat_err_q  <= lat_err_d;
    end
  end

  assign active    = (state_q != S_IDLE);
  assign valid     = (state_q == S_SERVE);
  assign buf_ptr   = ptr_q;
  assign desc_len  = len_q;
  assign desc_last = st_q[ST_LAST];
  assign desc_crc  = st_q[ST_CRC];

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !done && enable) |=> (valid && $stable(buf_ptr))); // R4
  AST_CLOSE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && done && enable) |=> (req && we && addr == $past(cur_q))); // R5
  AST_STOP_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WTST && enable && !rdata[LW + ST_OWN] && !poke_q && !act) |=> !active); // R3
endmodule

// File: rtl/dwr_arbiter.sv
module dwr_arbiter #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          rx_req,
  input  logic          rx_we,
  input  logic [AW-1:0] rx_addr,
  input  logic [DW-1:0] rx_wdata,
  input  logic          tx_req,
  input  logic          tx_we,
  input  logic [AW-1:0] tx_addr,
  input  logic [DW-1:0] tx_wdata,
  output logic          rx_gnt,
  output logic          tx_gnt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  // fixed priority: receive first, it cannot be throttled at the wire
  assign rx_gnt    = rx_req;
  assign tx_gnt    = tx_req && !rx_req;
  assign mem_req   = rx_req || tx_req;
  assign mem_we    = rx_req ? rx_we    : tx_we;
  assign mem_addr  = rx_req ? rx_addr  : tx_addr;
  assign mem_wdata = rx_req ? rx_wdata : tx_wdata;
endmodule

// File: rtl/dma_ring_walker.sv
module dma_ring_walker #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [AW-1:0] rx_base,
  input  logic [AW-1:0] tx_base,
  input  logic          act_we,
  input  logic [1:0]    act_target,
  input  logic [DW-1:0] act_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          rx_active,
  output logic          rx_valid,
  output logic [AW-1:0] rx_buf_ptr,
  input  logic          rx_done,
  input  logic [LW-1:0] rx_len,
  input  logic          rx_last,
  input  logic          rx_err,
  output logic          tx_active,
  output logic          tx_valid,
  output logic [AW-1:0] tx_buf_ptr,
  output logic [LW-1:0] tx_len,
  output logic          tx_last,
  output logic          tx_crc,
  input  logic          tx_done
);
  logic [1:0]    act_hit;
  logic          rx_req, rx_we, rx_gnt, tx_req, tx_we, tx_gnt;
  logic [AW-1:0] rx_addr, tx_addr;
  logic [DW-1:0] rx_wdata, tx_wdata;
  logic [LW-1:0] rx_dlen_nc;
  logic          rx_dlast_nc, rx_dcrc_nc;

  dwr_act_decode #(.DW(DW), .NENG(2)) i_act (
    .enable(enable), .act_we(act_we), .act_target(act_target),
    .act_data(act_data), .act_hit(act_hit)
  );

  dwr_ring_engine #(.AW(AW), .DW(DW), .LW(LW), .IS_RX(1'b1)) i_rx (
    .clk(clk), .rst_n(rst_n), .enable(enable), .base(rx_base), .act(act_hit[0]),
    .gnt(rx_gnt), .rdata(mem_rdata), .req(rx_req), .we(rx_we), .addr(rx_addr),
    .wdata(rx_wdata), .active(rx_active), .valid(rx_valid), .buf_ptr(rx_buf_ptr),
    .desc_len(rx_dlen_nc), .desc_last(rx_dlast_nc), .desc_crc(rx_dcrc_nc),
    .done(rx_done), .done_len(rx_len), .done_last(rx_last), .done_err(rx_err)
  );

  dwr_ring_engine #(.AW(AW), .DW(DW), .LW(LW), .IS_RX(1'b0)) i_tx (
    .clk(clk), .rst_n(rst_n), .enable(enable), .base(tx_base), .act(act_hit[1]),
    .gnt(tx_gnt), .rdata(mem_rdata), .req(tx_req), .we(tx_we), .addr(tx_addr),
    .wdata(tx_wdata), .active(tx_active), .valid(tx_valid), .buf_ptr(tx_buf_ptr),
    .desc_len(tx_len), .desc_last(tx_last), .desc_crc(tx_crc),
    .done(tx_done), .done_len('0), .done_last(1'b0), .done_err(1'b0)
  );

  dwr_arbiter #(.AW(AW), .DW(DW)) i_arb (
    .rx_req(rx_req), .rx_we(rx_we), .rx_addr(rx_addr), .rx_wdata(rx_wdata),
    .tx_req(tx_req), .tx_we(tx_we), .tx_addr(tx_addr), .tx_wdata(tx_wdata),
    .rx_gnt(rx_gnt), .tx_gnt(tx_gnt), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  AST_RX_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && tx_req) |-> (mem_addr == rx_addr && mem_we == rx_we)); // R10
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !mem_req); // R11
  AST_IDLE_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_active |-> !rx_valid); // R1
endmodule

// File: tb/test_dma_ring_walker.sv
`timescale 1ns/1ps
module test_dma_ring_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [31:0] rx_base, tx_base;
  logic        act_we;
  logic [1:0]  act_target;
  logic [31:0] act_data;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        rx_active, rx_valid, rx_done, rx_last, rx_err;
  logic [31:0] rx_buf_ptr, tx_buf_ptr;
  logic [15:0] rx_len, tx_len;
  logic        tx_active, tx_valid, tx_last, tx_crc, tx_done;

  int checks = 0, errors = 0;
  int pass_n = 1;
  int rx_idx = 0, tx_idx = 0;
  int acc_cnt = 0;
  logic [31:0] rlog [0:7];
  int nlog = 0;
  logic [31:0] last_rx_rd, last_tx_rd;
  logic [31:0] mem [0:63];

  always #2 clk = ~clk;

  dma_ring_walker i_dma_ring_walker (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rx_base(rx_base), .tx_base(tx_base),
    .act_we(act_we), .act_target(act_target), .act_data(act_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rx_active(rx_active), .rx_valid(rx_valid),
    .rx_buf_ptr(rx_buf_ptr), .rx_done(rx_done), .rx_len(rx_len), .rx_last(rx_last),
    .rx_err(rx_err), .tx_active(tx_active), .tx_valid(tx_valid), .tx_buf_ptr(tx_buf_ptr),
    .tx_len(tx_len), .tx_last(tx_last), .tx_crc(tx_crc), .tx_done(tx_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:2]];
    if (mem_req && mem_we)  mem[mem_addr[7:2]] <= mem_wdata;
  end

  // access monitor
  always @(negedge clk) begin
    if (mem_req) begin
      acc_cnt++;
      if (!mem_we) begin
        if (nlog < 8) begin rlog[nlog] = mem_addr; nlog++; end
        if (mem_addr >= 32'h40 && mem_addr < 32'h80 && mem_addr[2] == 1'b0) last_rx_rd = mem_addr;
        if (mem_addr >= 32'h80 && mem_addr < 32'hC0 && mem_addr[2] == 1'b0) last_tx_rd = mem_addr;
      end
    end
  end

  function automatic logic [15:0] rx_mac_len(int n, int i); return 16'(60 + 7*i + n); endfunction
  function automatic bit rx_mac_last(int i); return (i % 2) == 0; endfunction
  function automatic bit rx_mac_err(int i); return i == 1; endfunction
  function automatic logic [31:0] rx_ptr(int n, int i); return 32'h2000*n + 32*i; endfunction
  function automatic logic [31:0] tx_ptr(int n, int i); return 32'h1000*n + 16*i; endfunction
  function automatic logic [15:0] tx_dlen(int n, int i); return 16'(100 + 10*n + i); endfunction
  function automatic bit tx_dlast(int i); return i != 1; endfunction
  function automatic bit tx_dcrc(int i); return i != 2; endfunction

  // receive MAC responder
  always @(negedge clk) begin
    if (rx_done) rx_done <= 1'b0;
    else if (rx_valid) begin
      check(rx_buf_ptr == rx_ptr(pass_n, rx_idx), "R4", "rx buffer pointer", rx_buf_ptr, rx_ptr(pass_n, rx_idx));
      rx_len  <= rx_mac_len(pass_n, rx_idx);
      rx_last <= rx_mac_last(rx_idx);
      rx_err  <= rx_mac_err(rx_idx);
      rx_done <= 1'b1;
      rx_idx++;
    end
  end

  // transmit MAC responder
  always @(negedge clk) begin
    if (tx_done) tx_done <= 1'b0;
    else if (tx_valid) begin
      check(tx_buf_ptr == tx_ptr(pass_n, tx_idx), "R6", "tx pointer", tx_buf_ptr, tx_ptr(pass_n, tx_idx));
      check(tx_len == tx_dlen(pass_n, tx_idx), "R6", "tx length", 32'(tx_len), 32'(tx_dlen(pass_n, tx_idx)));
      check({tx_last, tx_crc} == {tx_dlast(tx_idx), tx_dcrc(tx_idx)}, "R6", "tx flags",
            32'({tx_last, tx_crc}), 32'({tx_dlast(tx_idx), tx_dcrc(tx_idx)}));
      tx_done <= 1'b1;
      tx_idx++;
    end
  end

  task automatic activate(input logic [1:0] tgt, input logic [31:0] data);
    @(negedge clk);
    act_we = 1'b1; act_target = tgt; act_data = data;
    @(negedge clk);
    act_we = 1'b0; act_target = 2'b00; act_data = '0;
  endtask

  task automatic wait_idle();
    int k;
    k = 0;
    repeat (3) @(negedge clk);
    while ((rx_active || tx_active || rx_done || tx_done) && k < 2000) begin
      @(negedge clk); k++;
    end
    check(k < 2000, "R3", "engines reached idle", 32'(k), 32'd2000);
  endtask

  task automatic quiet_window(input int cycles, input string req);
    int c0;
    c0 = acc_cnt;
    repeat (cycles) @(negedge clk);
    check(acc_cnt == c0, req, "no memory access while idle", 32'(acc_cnt - c0), 32'd0);
  endtask

  task automatic set_enable(input bit v);
    @(negedge clk); enable = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] exp;
    rst_n = 1'b0; enable = 1'b0; act_we = 1'b0; act_target = 2'b00; act_data = '0;
    rx_base = 32'h0000_0040; tx_base = 32'h0000_0085; // tx base low bits ignored
    rx_done = 1'b0; rx_len = '0; rx_last = 1'b0; rx_err = 1'b0; tx_done = 1'b0;
    for (int a = 0; a < 64; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req && !rx_active && !tx_active && !rx_valid && !tx_valid, "R1", "reset outputs quiet",
          32'({mem_req, rx_active, tx_active, rx_valid, tx_valid}), 32'd0);
    activate(2'b11, 32'h0100_0000); // enable low: ignored
    quiet_window(8, "R1");

    // ring size sweep, both rings started by one activate write
    for (int n = 1; n <= 4; n++) begin
      set_enable(1'b0);
      for (int a = 0; a < 64; a++) mem[a] = '0;
      for (int i = 0; i < n; i++) begin
        mem[16 + 2*i]     = {16'h8000 | ((i == n-1) ? 16'h2000 : 16'h0), 16'h0};
        mem[16 + 2*i + 1] = rx_ptr(n, i);
        mem[32 + 2*i]     = {16'h8000 | ((i == n-1) ? 16'h2000 : 16'h0) | (tx_dlast(i) ? 16'h0800 : 16'h0)
                             | (tx_dcrc(i) ? 16'h0400 : 16'h0), tx_dlen(n, i)};
        mem[32 + 2*i + 1] = tx_ptr(n, i);
      end
      pass_n = n; rx_idx = 0; tx_idx = 0;
      set_enable(1'b1);
      nlog = 0;
      activate(2'b11, 32'h0100_0000);
      wait_idle();
      check(nlog >= 2 && rlog[0] == 32'h40, "R10", "first access is rx base", rlog[0], 32'h40);
      check(nlog >= 2 && rlog[1] == 32'h80, "R2", "tx base read next, low bits dropped", rlog[1], 32'h80);
      check(rx_idx == n && tx_idx == n, "R10", "both rings fully served", 32'(rx_idx*16 + tx_idx), 32'(n*17));
      check(last_rx_rd == 32'h40, "R8", "rx wrapped to base", last_rx_rd, 32'h40);
      check(last_tx_rd == 32'h80, "R8", "tx wrapped to base", last_tx_rd, 32'h80);
      for (int i = 0; i < n; i++) begin
        exp = {((i == n-1) ? 16'h2000 : 16'h0) | (rx_mac_last(i) ? 16'h0800 : 16'h0) | (rx_mac_err(i) ? 16'h0001 : 16'h0),
               rx_mac_len(n, i) + (rx_mac_last(i) ? 16'd4 : 16'd0)};
        check(mem[16 + 2*i] == exp, "R5", "rx status writeback", mem[16 + 2*i], exp);
        exp = {((i == n-1) ? 16'h2000 : 16'h0) | (tx_dlast(i) ? 16'h0800 : 16'h0)
               | (tx_dcrc(i) ? 16'h0400 : 16'h0), tx_dlen(n, i)};
        check(mem[32 + 2*i] == exp, "R7", "tx status writeback", mem[32 + 2*i], exp);
      end
      check(!rx_active && !tx_active, "R3", "active flags low after unowned",
            32'({rx_active, tx_active}), 32'd0);
      quiet_window(20, "R3");
    end

    // activate values without bit 24 do nothing
    activate(2'b11, 32'h0000_0001);
    quiet_window(10, "R9");
    activate(2'b11, 32'hFEFF_FFFF);
    quiet_window(10, "R9");
    // a valid write restarts one poll at the (wrapped) base, which is unowned
    nlog = 0;
    activate(2'b01, 32'h0100_0000);
    repeat (6) @(negedge clk);
    check(nlog == 1 && rlog[0] == 32'h40, "R9", "single poll after valid activate", rlog[0], 32'h40);
    check(!rx_active, "R3", "rx stops on unowned descriptor", 32'(rx_active), 32'd0);

    // stop mid-ring, then disable: index must return to base
    set_enable(1'b0);
    for (int a = 0; a < 64; a++) mem[a] = '0;
    mem[16] = 32'h8000_0000; mem[17] = rx_ptr(5, 0);
    mem[18] = 32'h8000_0000; mem[19] = rx_ptr(5, 1);
    mem[20] = 32'h0000_0000; mem[21] = rx_ptr(5, 2);
    pass_n = 5; rx_idx = 0;
    set_enable(1'b1);
    activate(2'b01, 32'h0100_0000);
    wait_idle();
    check(last_rx_rd == 32'h50, "R8", "stepped by 8 to third descriptor", last_rx_rd, 32'h50);
    set_enable(1'b0);
    repeat (2) @(negedge clk);
    check(!mem_req && !rx_valid && !tx_valid, "R1", "quiet while disabled",
          32'({mem_req, rx_valid, tx_valid}), 32'd0);
    mem[16] = 32'h8000_0000; mem[18] = 32'h8000_0000; mem[20] = 32'hA000_0000;
    rx_idx = 0;
    set_enable(1'b1);
    nlog = 0;
    activate(2'b01, 32'h0100_0000);
    wait_idle();
    check(nlog >= 1 && rlog[0] == 32'h40, "R11", "restart at base after disable", rlog[0], 32'h40);
    check(rx_idx == 3, "R11", "all three descriptors served", 32'(rx_idx), 32'd3);
    check(last_rx_rd == 32'h40, "R8", "wrap after third descriptor", last_rx_rd, 32'h40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule